// File: doc/BRIEF.md
# Interrupt Priority Register File

This block holds one 8-bit priority value for each interrupt and serves single-cycle byte and word accesses to it. The byte address of an access is the interrupt ID. A byte access touches one interrupt. A word access touches four consecutive interrupts.

Access rights depend on two things: the security attribute that comes with each access, and a per-interrupt group bit supplied by the surrounding controller. When security is enabled, a non-secure master can only reach group-1 interrupts, and it sees those through a half-range view. A non-secure read returns the stored value shifted left by one. A non-secure write stores the written value shifted right by one, with the top bit forced to 1.

Read data is registered. After every write that changes storage, the block emits a one-cycle update pulse. The pulse carries the base interrupt ID and the number of lanes covered, so that downstream selection logic can re-evaluate those interrupts.

Top module: `prio_regfile`

## Requirements
- R1: Interrupt IDs below 32 read as zero through every access path, and writes to them never change storage.
- R2: IDs at or above NUM_IRQ (64 by default) read as zero, and byte writes to them are ignored.
- R3: A secure access, or any access while sec_disable_i is 1, reads and writes the stored byte unchanged.
- R4: A non-secure read of an interrupt whose group bit is 1, with sec_disable_i at 0, returns (stored << 1) truncated to 8 bits.
- R5: A non-secure write of an interrupt whose group bit is 1, with sec_disable_i at 0, stores 0x80 | (data >> 1).
- R6: With sec_disable_i at 0, non-secure accesses to interrupts whose group bit is 0 read as zero and leave storage unchanged.
- R7: Access size is selected by acc_word_i. When it is 1 (word), lanes ID, ID+1, ID+2 and ID+3 map to data bits [7:0], [15:8], [23:16] and [31:24], in that order. When it is 0 (byte), the access uses data bits [7:0] only, and rdata_o[31:8] reads as zero.
- R8: A word write is dropped completely when its base ID is below 32 or its base ID + 3 is at or above NUM_IRQ. Word reads are never dropped: each lane that falls outside the range reads as zero.
- R9: A word read applies R1 to R6 to each lane on its own, so lanes with different group bits yield different views within one word.
- R10: Read data appears on rdata_o in the cycle after the read request. It holds its value until the next read.
- R11: When a write changes at least one lane, upd_valid_o is 1 for exactly the next cycle, with upd_base_o equal to the access ID and upd_count_o equal to 1 for a byte or 4 for a word. Ignored writes produce no pulse.
- R12: After reset all priorities are zero, rdata_o is zero and upd_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access request this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_word_i | input | 1 | 1 = 4-lane word, 0 = single byte |
| acc_id_i | input | ADDR_W | Base interrupt ID (byte address) |
| acc_wdata_i | input | 32 | Write data, lane 0 in bits [7:0] |
| acc_secure_i | input | 1 | Access carries the secure attribute |
| group_i | input | NUM_IRQ | Per-interrupt group bit (1 = group 1) |
| sec_disable_i | input | 1 | Security disabled: all masters get the raw view |
| rdata_o | output | 32 | Registered read data |
| upd_valid_o | output | 1 | One-cycle update pulse |
| upd_base_o | output | ADDR_W | First interrupt ID covered by the update |
| upd_count_o | output | 3 | Number of interrupts covered (1 or 4) |

## Verification
The hardest case to reach is a single word that mixes lane outcomes. In such a word some lanes see the shifted non-secure view, some are blanked by their group bit, and some fall past the implemented range, while a write at the same position would be dropped as a whole. The bench gets there in three steps. First it loads neighbouring interrupts with distinct values through secure byte writes. Then it sets alternating group bits across those interrupts. Finally it issues non-secure word reads whose base sits inside the range and secure word reads whose base straddles the upper limit. Each expected word is built lane by lane from the rules.

// File: rtl/prio_pkg.sv
package prio_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned PRIO_W = 8;

  // restricted view covers the upper half of the priority range
  function automatic logic [PRIO_W-1:0] ns_read_view(input logic [PRIO_W-1:0] v);
    return {v[PRIO_W-2:0], 1'b0};
  endfunction

  function automatic logic [PRIO_W-1:0] ns_write_view(input logic [PRIO_W-1:0] w);
    return {1'b1, w[PRIO_W-1:1]};
  endfunction
endpackage

// File: rtl/prio_lane_view.sv
module prio_lane_view
  import prio_pkg::*;
(
  input  logic              impl_i,
  input  logic              group_i,
  input  logic              ns_restricted_i,
  input  logic [PRIO_W-1:0] stored_i,
  input  logic [PRIO_W-1:0] wdata_i,
  output logic [PRIO_W-1:0] rdata_o,
  output logic              wr_ok_o,
  output logic [PRIO_W-1:0] wr_data_o
);
  logic blocked;

  assign blocked = !impl_i || (ns_restricted_i && !group_i);

  always_comb begin
    if (blocked)              rdata_o = '0;
    else if (ns_restricted_i) rdata_o = ns_read_view(stored_i);
    else                      rdata_o = stored_i;
  end

  assign wr_ok_o   = !blocked;
  assign wr_data_o = ns_restricted_i ? ns_write_view(wdata_i) : wdata_i;
endmodule

// File: rtl/prio_store.sv
module prio_store
  import prio_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 32,
  parameter int unsigned IDX_W       = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [LANES-1:0]              wr_en_i,
  input  logic [LANES-1:0][IDX_W-1:0]   idx_i,
  input  logic [LANES-1:0][PRIO_W-1:0]  wr_data_i,
  output logic [LANES-1:0][PRIO_W-1:0]  rd_data_o
);
  logic [PRIO_W-1:0] mem [NUM_ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < NUM_ENTRIES; e++) mem[e] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_en_i[l] && (32'(idx_i[l]) < NUM_ENTRIES)) mem[idx_i[l]] <= wr_data_i[l];
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_rd
    assign rd_data_o[l] = (32'(idx_i[l]) < NUM_ENTRIES) ? mem[idx_i[l]] : '0;
  end

  // R7: lanes of one access never hit the same entry
  for (genvar a = 0; a < LANES; a++) begin : g_chk_a
    for (genvar b = a + 1; b < LANES; b++) begin : g_chk_b
      a_r7_distinct_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i[a] && wr_en_i[b]) |-> (idx_i[a] != idx_i[b]));
    end
  end
endmodule

// File: rtl/prio_regfile.sv
module prio_regfile
  import prio_pkg::*;
#(
  parameter int unsigned NUM_IRQ      = 64,
  parameter int unsigned INTERNAL_IDS = 32,
  parameter int unsigned ADDR_W       = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                acc_valid_i,
  input  logic                acc_write_i,
  input  logic                acc_word_i,
  input  logic [ADDR_W-1:0]   acc_id_i,
  input  logic [31:0]         acc_wdata_i,
  input  logic                acc_secure_i,
  input  logic [NUM_IRQ-1:0]  group_i,
  input  logic                sec_disable_i,
  output logic [31:0]         rdata_o,
  output logic                upd_valid_o,
  output logic [ADDR_W-1:0]   upd_base_o,
  output logic [2:0]          upd_count_o
);
  localparam int unsigned NUM_ENTRIES = NUM_IRQ - INTERNAL_IDS;
  localparam int unsigned IDX_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam int unsigned GRP_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int unsigned LID_W  = ADDR_W + 1;
  localparam logic [LID_W-1:0] LID_LO = LID_W'(INTERNAL_IDS);
  localparam logic [LID_W-1:0] LID_HI = LID_W'(NUM_IRQ);

  logic                          ns_restricted;
  logic [LID_W-1:0]              acc_lid;
  logic [LANES-1:0]              lane_impl, lane_grp, lane_active, lane_wr_ok, wr_en;
  logic [LANES-1:0][IDX_W-1:0]   lane_idx;
  logic [LANES-1:0][PRIO_W-1:0]  lane_stored, lane_rd, lane_wd;
  logic                          word_drop, is_read;
  logic [31:0]                   rd_next;

  assign ns_restricted = !acc_secure_i && !sec_disable_i;
  assign acc_lid       = {1'b0, acc_id_i};
  assign is_read       = acc_valid_i && !acc_write_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LID_W-1:0] lid, off;
    assign lid            = acc_lid + LID_W'(l);
    assign off            = lid - LID_LO;
    assign lane_impl[l]   = (lid >= LID_LO) && (lid < LID_HI);
    assign lane_idx[l]    = lane_impl[l] ? off[IDX_W-1:0] : '0;
    assign lane_grp[l]    = lane_impl[l] ? group_i[lid[GRP_W-1:0]] : 1'b0;
    assign lane_active[l] = (l == 0) || acc_word_i;

    prio_lane_view u_view (
      .impl_i          (lane_impl[l]),
      .group_i         (lane_grp[l]),
      .ns_restricted_i (ns_restricted),
      .stored_i        (lane_stored[l]),
      .wdata_i         (acc_wdata_i[8*l +: 8]),
      .rdata_o         (lane_rd[l]),
      .wr_ok_o         (lane_wr_ok[l]),
      .wr_data_o       (lane_wd[l])
    );

    assign wr_en[l] = acc_valid_i && acc_write_i && lane_active[l] && lane_wr_ok[l] && !word_drop;

    // R6: restricted writes only reach group-1 interrupts
    a_r6_ns_group_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en[l] && ns_restricted) |-> group_i[lid[GRP_W-1:0]]);
  end

  // whole word is dropped if first or last lane is outside the implemented range
  assign word_drop = acc_word_i && !(lane_impl[0] && lane_impl[LANES-1]);

  prio_store #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .idx_i     (lane_idx),
    .wr_data_i (lane_wd),
    .rd_data_o (lane_stored)
  );

  assign rd_next = acc_word_i ? {lane_rd[3], lane_rd[2], lane_rd[1], lane_rd[0]}
                              : {24'h0, lane_rd[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o     <= '0;
      upd_valid_o <= 1'b0;
      upd_base_o  <= '0;
      upd_count_o <= '0;
    end else begin
      if (is_read) rdata_o <= rd_next;
      upd_valid_o <= |wr_en;
      if (|wr_en) begin
        upd_base_o  <= acc_id_i;
        upd_count_o <= acc_word_i ? 3'd4 : 3'd1;
      end
    end
  end

  a_r1_internal_no_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_write_i && acc_lid < LID_LO) |=> !upd_valid_o);

  a_r2_unimpl_no_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_write_i && !acc_word_i && acc_lid >= LID_HI) |=> !upd_valid_o);

  a_r8_word_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_write_i && acc_word_i && (acc_lid + LID_W'(3) >= LID_HI)) |=> !upd_valid_o);

  a_r10_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_read |=> $stable(rdata_o));

  a_r11_update_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |-> $past(acc_valid_i && acc_write_i));

  a_r11_count_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |-> (upd_count_o == 3'd1 || upd_count_o == 3'd4));

  a_r7_byte_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_read && !acc_word_i) |=> (rdata_o[31:8] == 24'h0));
endmodule

// File: tb/prio_regfile_bench.sv
module prio_regfile_bench;
  localparam int NUM_IRQ = 64;
  localparam int ADDR_W  = 10;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              acc_valid_i = 1'b0, acc_write_i = 1'b0, acc_word_i = 1'b0;
  logic [ADDR_W-1:0] acc_id_i = '0;
  logic [31:0]       acc_wdata_i = '0;
  logic              acc_secure_i = 1'b1;
  logic [NUM_IRQ-1:0] group_i = '0;
  logic              sec_disable_i = 1'b0;
  logic [31:0]       rdata_o;
  logic              upd_valid_o;
  logic [ADDR_W-1:0] upd_base_o;
  logic [2:0]        upd_count_o;

  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  prio_regfile #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_prio_regfile (
    .clk_i(clk), .rst_ni(rst_ni), .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i),
    .acc_word_i(acc_word_i), .acc_id_i(acc_id_i), .acc_wdata_i(acc_wdata_i),
    .acc_secure_i(acc_secure_i), .group_i(group_i), .sec_disable_i(sec_disable_i),
    .rdata_o(rdata_o), .upd_valid_o(upd_valid_o), .upd_base_o(upd_base_o),
    .upd_count_o(upd_count_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // one access; returns outputs seen after the capturing edge
  task automatic acc(input logic wr, input logic word, input int id, input logic [31:0] d,
                     input logic sec, output logic [31:0] rd, output logic uv,
                     output logic [ADDR_W-1:0] ub, output logic [2:0] uc);
    @(negedge clk);
    acc_valid_i = 1'b1; acc_write_i = wr; acc_word_i = word;
    acc_id_i = ADDR_W'(id); acc_wdata_i = d; acc_secure_i = sec;
    @(negedge clk);
    acc_valid_i = 1'b0; acc_write_i = 1'b0;
    rd = rdata_o; uv = upd_valid_o; ub = upd_base_o; uc = upd_count_o;
  endtask

  task automatic wr_b(input int id, input logic [7:0] d, input logic sec, output logic uv);
    logic [31:0] rd; logic [ADDR_W-1:0] ub; logic [2:0] uc;
    acc(1'b1, 1'b0, id, {24'h0, d}, sec, rd, uv, ub, uc);
  endtask

  task automatic rd_x(input logic word, input int id, input logic sec, output logic [31:0] rd);
    logic uv; logic [ADDR_W-1:0] ub; logic [2:0] uc;
    acc(1'b0, word, id, 32'h0, sec, rd, uv, ub, uc);
  endtask

  task automatic t_reset();
    logic [31:0] rd;
    chk("R12 upd_valid after reset", {31'h0, upd_valid_o}, 32'h0);
    chk("R12 rdata after reset", rdata_o, 32'h0);
    rd_x(1'b0, 40, 1'b1, rd);
    chk("R12 priority after reset", rd, 32'h0);
  endtask

  task automatic t_secure_byte();
    logic [31:0] rd; logic uv; logic [ADDR_W-1:0] ub; logic [2:0] uc;
    acc(1'b1, 1'b0, 40, 32'hFFFF_FF5A, 1'b1, rd, uv, ub, uc);
    chk("R11 byte pulse", {31'h0, uv}, 32'h1);
    chk("R11 byte base", 32'(ub), 32'd40);
    chk("R11 byte count", 32'(uc), 32'd1);
    @(negedge clk);
    chk("R11 pulse one cycle", {31'h0, upd_valid_o}, 32'h0);
    rd_x(1'b0, 40, 1'b1, rd);
    chk("R3 secure raw read", rd, 32'h5A);
    chk("R7 byte upper zero", rd & 32'hFFFF_FF00, 32'h0);
  endtask

  task automatic t_internal();
    logic [31:0] rd; logic uv;
    wr_b(10, 8'hFF, 1'b1, uv);
    chk("R1 internal write no pulse", {31'h0, uv}, 32'h0);
    rd_x(1'b0, 10, 1'b1, rd);
    chk("R1 internal reads zero", rd, 32'h0);
    wr_b(31, 8'h12, 1'b1, uv);
    rd_x(1'b0, 31, 1'b1, rd);
    chk("R1 id 31 reads zero", rd, 32'h0);
  endtask

  task automatic t_unimpl();
    logic [31:0] rd; logic uv;
    wr_b(70, 8'h33, 1'b1, uv);
    chk("R2 unimplemented write no pulse", {31'h0, uv}, 32'h0);
    rd_x(1'b0, 70, 1'b1, rd);
    chk("R2 unimplemented reads zero", rd, 32'h0);
    wr_b(64, 8'h44, 1'b1, uv);
    chk("R2 id 64 write no pulse", {31'h0, uv}, 32'h0);
  endtask

  task automatic t_nonsecure();
    logic [31:0] rd; logic uv;
    group_i[40] = 1'b1; group_i[41] = 1'b0;
    rd_x(1'b0, 40, 1'b0, rd);
    chk("R4 ns shifted read", rd, 32'hB4);
    wr_b(40, 8'h44, 1'b0, uv);
    chk("R11 ns write pulse", {31'h0, uv}, 32'h1);
    rd_x(1'b0, 40, 1'b1, rd);
    chk("R5 ns write stored", rd, 32'hA2);
    wr_b(41, 8'h33, 1'b1, uv);
    wr_b(41, 8'h11, 1'b0, uv);
    chk("R6 ns write group0 no pulse", {31'h0, uv}, 32'h0);
    rd_x(1'b0, 41, 1'b0, rd);
    chk("R6 ns read group0 zero", rd, 32'h0);
    rd_x(1'b0, 41, 1'b1, rd);
    chk("R6 group0 value kept", rd, 32'h33);
  endtask

  task automatic t_secdis();
    logic [31:0] rd; logic uv;
    sec_disable_i = 1'b1;
    wr_b(41, 8'h77, 1'b0, uv);
    rd_x(1'b0, 41, 1'b0, rd);
    chk("R3 sec disabled raw access", rd, 32'h77);
    sec_disable_i = 1'b0;
  endtask

  task automatic t_word();
    logic [31:0] rd; logic uv; logic [ADDR_W-1:0] ub; logic [2:0] uc;
    acc(1'b1, 1'b1, 44, 32'h4433_2211, 1'b1, rd, uv, ub, uc);
    chk("R11 word pulse", {31'h0, uv}, 32'h1);
    chk("R11 word base", 32'(ub), 32'd44);
    chk("R11 word count", 32'(uc), 32'd4);
    rd_x(1'b0, 44, 1'b1, rd);
    chk("R7 lane0 byte", rd, 32'h11);
    rd_x(1'b0, 47, 1'b1, rd);
    chk("R7 lane3 byte", rd, 32'h44);
    rd_x(1'b1, 44, 1'b1, rd);
    chk("R7 word read", rd, 32'h4433_2211);
  endtask

  task automatic t_word_drop();
    logic [31:0] rd; logic uv; logic [ADDR_W-1:0] ub; logic [2:0] uc;
    acc(1'b1, 1'b1, 61, 32'h0102_0304, 1'b1, rd, uv, ub, uc);
    chk("R8 high word drop no pulse", {31'h0, uv}, 32'h0);
    rd_x(1'b0, 61, 1'b1, rd);
    chk("R8 high word drop lane kept", rd, 32'h0);
    acc(1'b1, 1'b1, 30, 32'h0908_0706, 1'b1, rd, uv, ub, uc);
    chk("R8 low word drop no pulse", {31'h0, uv}, 32'h0);
    rd_x(1'b0, 32, 1'b1, rd);
    chk("R8 low word drop lane kept", rd, 32'h0);
    acc(1'b1, 1'b1, 60, 32'hDDCC_BBAA, 1'b1, rd, uv, ub, uc);
    chk("R8 last full word accepted", {31'h0, uv}, 32'h1);
    rd_x(1'b1, 62, 1'b1, rd);
    chk("R8 straddling word read", rd, 32'h0000_DDCC);
  endtask

  task automatic t_mixed();
    logic [31:0] rd, hold; logic uv;
    // stored: 40=A2 41=77 ; program 42,43
    wr_b(42, 8'h81, 1'b1, uv);
    wr_b(43, 8'h12, 1'b1, uv);
    group_i[42] = 1'b1; group_i[43] = 1'b0;
    rd_x(1'b1, 40, 1'b0, rd);
    chk("R9 mixed ns word", rd, 32'h0002_0044);
    hold = rd;
    wr_b(50, 8'h66, 1'b1, uv);
    @(negedge clk);
    chk("R10 rdata holds", rdata_o, hold);
    rd_x(1'b1, 40, 1'b1, rd);
    chk("R9 secure word raw", rd, 32'h1281_77A2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_secure_byte();
    t_internal();
    t_unimpl();
    t_nonsecure();
    t_secdis();
    t_word();
    t_word_drop();
    t_mixed();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule